// File: doc/BRIEF.md
# Grayscale Cycle Sequencer for Chained PWM LED Drivers

This block produces the control waveforms for a chain of constant-current PWM LED driver devices. It divides the system clock down into a square grayscale clock and counts a fixed number of grayscale periods per cycle. Between cycles it stops that clock, raises a blanking signal and, when fresh data is waiting in the drivers' shift registers, pulses a latch strobe in the middle of the blanking interval.

A companion serial shifter, which is outside this block, moves the data. The sequencer opens a clear-to-send window as each cycle starts and closes it two thirds of the way through. This leaves every transfer room to finish before the next blank. The shifter asks to start a transfer, receives a grant only while the window is open, and reports when it is done. Only a granted transfer that completes marks data as pending for the next latch.

A global enable darkens the outputs. Dropping it stops the grayscale clock and then raises blanking straight away. Raising it lets the outputs light only once the current cycle's blanking interval ends. From reset the outputs are blanked.

Top module: `gsq_seq`

## Requirements
- R1: While enabled and outside blanking, `gsclk_o` is a square wave of period 2*DIV_HALF system clocks that starts low. Its first rising edge comes DIV_HALF clocks after blanking ends. A cycle holds exactly CYCLE_LEN rising edges and ends at the falling edge that follows the last of them.
- R2: After that final falling edge, `gsclk_o` stays low for exactly one system clock before `blank_o` rises. The blanking interval then lasts BLANK_LEN system clocks (BLANK_LEN >= 2), and `gsclk_o` is low throughout.
- R3: `xlat_o` is high for one system clock at blanking clock index (BLANK_LEN-1)/2, counting from 0. It fires only if a completed transfer is pending, and firing clears the pending state. `blank_o` is always high while `xlat_o` is high.
- R4: `cts_o` rises on the first clock after each blanking interval. It falls on the clock after the rising grayscale edge numbered WIN = floor(2*CYCLE_LEN/3), unless it has already closed.
- R5: `xfer_go_o` is high in the same clock as `xfer_req_i` only while `cts_o` is high, and a grant closes `cts_o` on the next clock. A request while `cts_o` is low gets no grant and has no effect.
- R6: A pulse on `xfer_done_i` marks data as pending only after a granted request that has not yet reported done. A done pulse with no open grant is ignored and produces no latch pulse.
- R7: If `enable_i` is low at a clock edge, `gsclk_o` is low from that edge on. `blank_o` goes high one clock later and stays high while `enable_i` remains low.
- R8: After `enable_i` returns high, `blank_o` falls only at the end of the next blanking interval. The cycle timing, window and latch continue to run while the block is disabled.
- R9: During reset `blank_o` is high and `gsclk_o`, `xlat_o`, `cts_o` and `xfer_go_o` are low. After reset a blanking interval of BLANK_LEN clocks runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Global output enable |
| xfer_req_i | input | 1 | Shifter asks to start a transfer |
| xfer_done_i | input | 1 | Shifter reports a granted transfer finished |
| gsclk_o | output | 1 | Grayscale clock to the driver chain |
| blank_o | output | 1 | Blanking signal, high turns outputs off |
| xlat_o | output | 1 | One-clock latch strobe during blanking |
| cts_o | output | 1 | Clear-to-send window flag |
| xfer_go_o | output | 1 | Grant for the current request |

## Verification
The bench builds the block with DIV_HALF=2, CYCLE_LEN=12 and BLANK_LEN=5. A whole cycle is therefore 54 system clocks, and several dozen cycles fit into a short run. With a divider above one, the bench can observe the half-period counter and the start-low phase. The odd blanking length places the latch strobe at index 2, away from either edge of the blank. A cycle of twelve edges puts the window close at edge eight, so random requests land both inside and outside the window. Enable toggles at a variety of cycle phases, so drop-outs in mid-cycle and resumes that wait for the blank are both reached.

// File: rtl/gsq_pkg.sv
package gsq_pkg;
   typedef enum logic [1:0] {
      ST_BLANK = 2'd0,
      ST_RUN   = 2'd1,
      ST_STOP  = 2'd2
   } seq_st_t;
endpackage

// File: rtl/gsq_clkdiv.sv
module gsq_clkdiv #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic ph_o,
   output logic rise_o,
   output logic fall_o
);
   logic tick;

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("gsq_clkdiv: DIV_HALF must be at least 1");
      end
      if (DIV_HALF == 1) begin : g_direct
         assign tick = run_i;
      end else begin : g_count
         localparam int CW = $clog2(DIV_HALF);
         localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt <= '0;
            else if (!run_i)         cnt <= '0;
            else if (cnt == LAST)    cnt <= '0;
            else                     cnt <= cnt + 1'b1;
         end
         assign tick = run_i && (cnt == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ph_o <= 1'b0;
      else if (!run_i)  ph_o <= 1'b0;
      else if (tick)    ph_o <= ~ph_o;
   end

   assign rise_o = tick & ~ph_o;
   assign fall_o = tick & ph_o;

   // R1: a rising strobe leaves the phase high on the next clock
   p_rise_sets_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> ph_o);
   // R1: the phase is always low when the divider is held
   p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !ph_o);
endmodule

// File: rtl/gsq_cycle.sv
module gsq_cycle
   import gsq_pkg::*;
#(
   parameter int CYCLE_LEN = 4096,
   parameter int BLANK_LEN = 4,
   parameter int WIN_LEN   = 2730
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    rise_i,
   input  logic    fall_i,
   output seq_st_t st_o,
   output logic    open_o,
   output logic    close_o,
   output logic    slot_o
);
   localparam int GW = $clog2(CYCLE_LEN + 1);
   localparam int BW = $clog2(BLANK_LEN);
   localparam logic [GW-1:0] GS_LAST  = GW'(CYCLE_LEN);
   localparam logic [GW-1:0] WIN_EDGE = GW'(WIN_LEN - 1);
   localparam logic [BW-1:0] BL_LAST  = BW'(BLANK_LEN - 1);
   localparam logic [BW-1:0] XL_AT    = BW'((BLANK_LEN - 1) / 2);

   generate
      if (BLANK_LEN < 2) begin : g_bad_blank
         $error("gsq_cycle: BLANK_LEN must be at least 2");
      end
      if (WIN_LEN < 1 || WIN_LEN >= CYCLE_LEN) begin : g_bad_win
         $error("gsq_cycle: WIN_LEN must lie in 1..CYCLE_LEN-1");
      end
   endgenerate

   logic [GW-1:0] gs_cnt;
   logic [BW-1:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_o   <= ST_BLANK;
         gs_cnt <= '0;
         bcnt   <= '0;
      end else begin
         case (st_o)
            ST_RUN: begin
               if (fall_i && gs_cnt == GS_LAST) begin
                  st_o   <= ST_STOP;
                  gs_cnt <= '0;
               end else if (rise_i) begin
                  gs_cnt <= gs_cnt + 1'b1;
               end
            end
            ST_STOP: begin
               st_o <= ST_BLANK;
               bcnt <= '0;
            end
            ST_BLANK: begin
               if (bcnt == BL_LAST) begin
                  st_o <= ST_RUN;
                  bcnt <= '0;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            default: st_o <= ST_BLANK;
         endcase
      end
   end

   assign open_o  = (st_o == ST_BLANK) && (bcnt == BL_LAST);
   assign close_o = rise_i && (gs_cnt == WIN_EDGE);
   assign slot_o  = (st_o == ST_BLANK) && (bcnt == XL_AT);

   // R1: the edge count never passes the cycle length
   p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      gs_cnt <= GS_LAST);
   // R1: grayscale edges only occur in the running phase
   p_edges_in_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i || fall_i) |-> st_o == ST_RUN);
   // R2: the stopped-clock gap lasts a single clock
   p_stop_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      st_o == ST_STOP |=> st_o == ST_BLANK);
endmodule

// File: rtl/gsq_xfer_win.sv
module gsq_xfer_win (
   input  logic clk,
   input  logic rst_n,
   input  logic open_i,
   input  logic close_i,
   input  logic req_i,
   input  logic done_i,
   input  logic xlat_i,
   output logic cts_o,
   output logic go_o,
   output logic pend_o
);
   logic busy;
   logic finish;

   assign go_o   = cts_o & req_i;
   assign finish = done_i & busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cts_o  <= 1'b0;
         busy   <= 1'b0;
         pend_o <= 1'b0;
      end else begin
         if (open_i)                cts_o <= 1'b1;
         else if (go_o || close_i)  cts_o <= 1'b0;

         if (finish)                busy <= 1'b0;
         else if (go_o)             busy <= 1'b1;

         if (finish)                pend_o <= 1'b1;
         else if (xlat_i)           pend_o <= 1'b0;
      end
   end

   // R5: a grant shuts the window on the following clock
   p_grant_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go_o && !open_i) |=> !cts_o);
   // R3: a latch pulse consumes the pending data
   p_latch_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xlat_i && !finish) |=> !pend_o);
   // R6: pending data only appears after a done report
   p_pend_from_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_o) |-> $past(done_i));
endmodule

// File: rtl/gsq_seq.sv
module gsq_seq
   import gsq_pkg::*;
#(
   parameter int DIV_HALF  = 2,
   parameter int CYCLE_LEN = 4096,
   parameter int BLANK_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  logic xfer_req_i,
   input  logic xfer_done_i,
   output logic gsclk_o,
   output logic blank_o,
   output logic xlat_o,
   output logic cts_o,
   output logic xfer_go_o
);
   localparam int WIN_LEN = (CYCLE_LEN * 2) / 3;

   generate
      if (CYCLE_LEN < 3) begin : g_bad_cycle
         $error("gsq_seq: CYCLE_LEN must be at least 3");
      end
   endgenerate

   seq_st_t st;
   logic ph, rise, fall;
   logic open_w, close_w, slot_w, pend_w;
   logic live;

   gsq_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (st == ST_RUN),
      .ph_o   (ph),
      .rise_o (rise),
      .fall_o (fall)
   );

   gsq_cycle #(
      .CYCLE_LEN (CYCLE_LEN),
      .BLANK_LEN (BLANK_LEN),
      .WIN_LEN   (WIN_LEN)
   ) u_cycle (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (rise),
      .fall_i  (fall),
      .st_o    (st),
      .open_o  (open_w),
      .close_o (close_w),
      .slot_o  (slot_w)
   );

   gsq_xfer_win u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .open_i  (open_w),
      .close_i (close_w),
      .req_i   (xfer_req_i),
      .done_i  (xfer_done_i),
      .xlat_i  (xlat_o),
      .cts_o   (cts_o),
      .go_o    (xfer_go_o),
      .pend_o  (pend_w)
   );

   // live follows enable immediately on a drop, but only at a blank end on a rise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live    <= 1'b0;
         blank_o <= 1'b1;
      end else begin
         if (open_w)          live <= enable_i;
         else if (!enable_i)  live <= 1'b0;

         if (open_w && enable_i)             blank_o <= 1'b0;
         else if (st == ST_STOP || !live)    blank_o <= 1'b1;
      end
   end

   assign gsclk_o = ph & live;
   assign xlat_o  = slot_w & pend_w;

   // R2: the grayscale clock is never high during blanking
   p_no_clock_in_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      blank_o |-> !gsclk_o);
   // R2: blanking only rises after the grayscale clock was already low
   p_low_before_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blank_o) |-> !$past(gsclk_o));
   // R3: the latch strobe falls inside blanking
   p_latch_in_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_o |-> blank_o);
   // R7: a low enable stops the grayscale clock at the next edge
   p_dark_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> !gsclk_o);
   // R7: two clocks of low enable leave the outputs blanked
   p_blank_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable_i && $past(!enable_i)) |=> blank_o);
endmodule

// File: tb/tb_gsq_seq.sv
module tb_gsq_seq;
   localparam int DH   = 2;
   localparam int CL   = 12;
   localparam int BL   = 5;
   localparam int WIN  = (CL * 2) / 3;
   localparam int XAT  = (BL - 1) / 2;
   localparam int RUNL = 2 * DH * CL;
   localparam int PER  = BL + RUNL + 1;
   localparam int NCLK = 2400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, req = 1'b0, done = 1'b0;
   logic gsclk, blank, xlat, cts, go;

   int errs = 0, checks = 0, cyc = 0;
   bit fin = 1'b0;

   // bench model of the requirements
   int  m_pos = 0;
   bit  m_live = 0, m_blank = 1, m_cts = 0, m_busy = 0, m_pend = 0;
   int  sh_cnt = 0;

   always #5 clk = ~clk;

   gsq_seq #(.DIV_HALF(DH), .CYCLE_LEN(CL), .BLANK_LEN(BL)) dut (
      .clk (clk), .rst_n (rst_n), .enable_i (en), .xfer_req_i (req),
      .xfer_done_i (done), .gsclk_o (gsclk), .blank_o (blank),
      .xlat_o (xlat), .cts_o (cts), .xfer_go_o (go)
   );

   function automatic bit in_run(int p);
      return (p >= BL) && (p < BL + RUNL);
   endfunction

   function automatic bit exp_gsclk();
      if (!in_run(m_pos) || !m_live) return 1'b0;
      return ((m_pos - BL) / DH) % 2 == 1;
   endfunction

   function automatic bit exp_xlat();
      return (m_pos == XAT) && m_pend;
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s clk=%0d actual=%0b expected=%0b", tag, cyc, act, exp);
      end
   endtask

   task automatic model_step();
      bit g, bend, stp, cls, fin_x, xl;
      g     = m_cts && req;
      bend  = (m_pos == BL - 1);
      stp   = (m_pos == PER - 1);
      cls   = in_run(m_pos) && (m_pos - BL == (2 * WIN - 1) * DH - 1);
      fin_x = done && m_busy;
      xl    = exp_xlat();
      if (bend && en)              m_blank = 0;
      else if (stp || !m_live)     m_blank = 1;
      if (bend)                    m_live = en;
      else if (!en)                m_live = 0;
      if (bend)                    m_cts = 1;
      else if (g || cls)           m_cts = 0;
      if (fin_x)                   m_pend = 1;
      else if (xl)                 m_pend = 0;
      if (fin_x)                   m_busy = 0;
      else if (g)                  m_busy = 1;
      m_pos = (m_pos + 1) % PER;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset blank", blank, 1'b1);
      chk("R9 reset gsclk", gsclk, 1'b0);
      chk("R9 reset xlat", xlat, 1'b0);
      chk("R9 reset cts", cts, 1'b0);
      chk("R9 reset go", go, 1'b0);
      rst_n = 1'b1;
      void'($urandom(32'd5150));
      for (int i = 0; i < NCLK; i++) begin
         @(negedge clk);
         cyc = i;
         model_step();
         chk("R1 gsclk", gsclk, exp_gsclk());
         chk("R2 R7 R8 blank", blank, m_blank);
         chk("R3 R6 xlat", xlat, exp_xlat());
         chk("R4 cts", cts, m_cts);
         chk("R5 go", go, m_cts && req);
         if (req && go) sh_cnt = 1 + int'($urandom % 6);
         // next inputs
         req  = 1'b0;
         done = 1'b0;
         if (sh_cnt > 0) begin
            sh_cnt--;
            if (sh_cnt == 0) done = 1'b1;
         end else begin
            req = ($urandom % 9) == 0;
            if (!req && ($urandom % 25) == 0) done = 1'b1; // stray done, R6
         end
         if (i < 70)             en = 1'b0;
         else if (i < 400)       en = 1'b1;
         else if (i < 430)       en = 1'b0;   // mid-cycle drop, R7
         else if (i < 700)       en = 1'b1;   // resume waits for blank, R8
         else if (($urandom % 37) == 0) en = ~en;
      end
      fin = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         errs++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule